// File: doc/BRIEF.md
# Reader Power-Mode and Startup Sequencer

This block controls the power states of a contactless reader core. When power-on reset is asserted or the external power-down pin is high, the block holds the core in hard power-down. After that it steps through a reset phase, an initialising phase and a ready phase. Each phase has a fixed length in clock cycles. The pin high period must reach a programmed minimum width before it starts the sequence. A shorter pulse leaves the core parked in hard power-down until a qualifying pulse or a power-on reset arrives.

Once the core is ready, software can set a standby bit. Standby takes effect on the next cycle and turns off the internal clock buffer and the current sinks. When software clears the bit, the core leaves standby only after a fixed number of oscillator cycles, and the bit reads back as set until then. A separate auto-power-down bit chooses between two receiver modes. In one mode the receiver supply stays on in the ready state. In the other it follows a "receiver in use" strobe.

Top module: `rdr_pwr_seq`

## Requirements
- R1: During and right after synchronous reset, the outputs are as follows: hard power-down indicator 1, the other three phase indicators 0, clock buffer enable 1, current sink enable 0, receiver power 0, standby bit 0, auto-power-down bit 0. The current sink enable is 0 in every cycle in hard power-down.
- R2: When power-on reset or the pin is sampled high at a clock edge, the block is in hard power-down after that edge, from any phase. Standby and the auto-power-down bit are cleared by that edge.
- R3: A pin pulse must stay high for at least PULSE_MIN consecutive sampled cycles to arm the startup sequence. A pulse with PULSE_MIN-1 or fewer high samples leaves the block in hard power-down. Power-on reset and synchronous reset always arm it.
- R4: When the block is armed in hard power-down, the first edge with both power-on reset and pin low moves it to the reset phase.
- R5: The reset phase lasts RST_CYC cycles, then the initialising phase lasts INIT_CYC cycles, then ready holds. Exactly one phase indicator is high in every cycle.
- R6: A standby write of 1 sampled in the ready phase sets the standby bit at the next edge. The clock buffer enable and the current sink enable drop at that same edge.
- R7: A standby write of 1 sampled outside the ready phase is ignored, and the standby bit stays 0.
- R8: A standby write of 0 sampled at edge e while in standby clears the standby bit at edge e+STBY_EXIT. Until then the bit reads 1 and both enables stay low. A write of 1 during that countdown cancels the exit.
- R9: With the auto-power-down bit at 0, receiver power is 1 one cycle after any cycle that is in ready and not in standby. Receiver power is 0 after any other cycle.
- R10: With the auto-power-down bit at 1, receiver power after an edge equals the receiver-in-use input sampled at that edge, ANDed with ready and not-standby. The bit takes the written value one edge after its write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | oscillator clock |
| rst | input | 1 | synchronous active-high reset |
| por_i | input | 1 | power-on reset request |
| pd_pin_i | input | 1 | external power-down/reset pin, active high |
| stby_wr_i | input | 1 | write strobe for the standby bit |
| stby_wdata_i | input | 1 | value written to the standby bit |
| apd_wr_i | input | 1 | write strobe for the auto-power-down bit |
| apd_wdata_i | input | 1 | value written to the auto-power-down bit |
| rx_busy_i | input | 1 | receiver in use |
| ph_hpd_o | output | 1 | hard power-down phase |
| ph_rst_o | output | 1 | reset phase |
| ph_init_o | output | 1 | initialising phase |
| ph_rdy_o | output | 1 | ready phase |
| clkbuf_en_o | output | 1 | internal digital clock buffer enable |
| sink_en_o | output | 1 | internal current sink enable |
| rx_pwr_o | output | 1 | receiver power enable |
| stby_bit_o | output | 1 | standby bit read-back |
| apd_bit_o | output | 1 | auto-power-down bit read-back |

## Verification
Every output is registered, so every input takes effect one edge after it is sampled. Power-down, a standby set, an auto-power-down write and a receiver strobe all show at the next sample. The reset-to-initialising and initialising-to-ready steps fall RST_CYC and INIT_CYC edges after the phase starts. A standby clear shows STBY_EXIT edges after its write. Inputs change only on the falling edge and outputs are read on the falling edge. The directed checks count falling edges from the stimulus to the cycle in which the result is due. A per-cycle model, stepped on each rising edge, is compared against all outputs on every falling edge during the random run.

// File: rtl/rps_pkg.sv
package rps_pkg;

    typedef enum logic [1:0] {
        PH_HPD  = 2'd0,
        PH_RST  = 2'd1,
        PH_INIT = 2'd2,
        PH_RDY  = 2'd3
    } rps_phase_e;

    typedef struct packed {
        logic active;
        logic exiting;
    } rps_stby_t;

    // counter width able to hold values 0..n
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rps_pulse_qual.sv
module rps_pulse_qual
    import rps_pkg::*;
#(
    parameter int PULSE_MIN = 1356
) (
    input  logic clk,
    input  logic rst,
    input  logic por,
    input  logic pin,
    input  logic in_hpd,
    output logic armed
);
    localparam int HW = cnt_w(PULSE_MIN);

    logic leave;
    assign leave = in_hpd && !por && !pin && armed;

    generate
        if (PULSE_MIN <= 1) begin : g_any
            always_ff @(posedge clk) begin
                if (rst || por || pin) begin
                    armed <= 1'b1;
                end else if (leave) begin
                    armed <= 1'b0;
                end
            end
        end else begin : g_count
            localparam logic [HW-1:0] LAST = HW'(PULSE_MIN - 1);
            logic [HW-1:0] hcnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    armed <= 1'b1;
                    hcnt  <= '0;
                end else if (por) begin
                    armed <= 1'b1;
                    hcnt  <= '0;
                end else if (pin) begin
                    if (hcnt == LAST) begin
                        armed <= 1'b1;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end else begin
                    hcnt <= '0;
                    if (leave) begin
                        armed <= 1'b0;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rps_phase_seq.sv
module rps_phase_seq
    import rps_pkg::*;
#(
    parameter int RST_CYC  = 1356,
    parameter int INIT_CYC = 1356
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       kill,
    input  logic       armed,
    output rps_phase_e phase
);
    localparam int PW = cnt_w(max2(RST_CYC, INIT_CYC));
    localparam logic [PW-1:0] RST_LAST  = PW'(RST_CYC - 1);
    localparam logic [PW-1:0] INIT_LAST = PW'(INIT_CYC - 1);

    logic [PW-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            phase <= PH_HPD;
            pcnt  <= '0;
        end else begin
            unique case (phase)
                PH_HPD: begin
                    pcnt <= '0;
                    if (armed) phase <= PH_RST;
                end
                PH_RST: begin
                    if (pcnt == RST_LAST) begin
                        phase <= PH_INIT;
                        pcnt  <= '0;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                PH_INIT: begin
                    if (pcnt == INIT_LAST) begin
                        phase <= PH_RDY;
                        pcnt  <= '0;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                default: begin
                    pcnt <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/rps_standby.sv
module rps_standby
    import rps_pkg::*;
#(
    parameter int STBY_EXIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic kill,
    input  logic ready,
    input  logic wr,
    input  logic wdata,
    output logic active
);
    localparam int EW = cnt_w(STBY_EXIT);
    localparam logic [EW-1:0] EXIT_LAST = EW'(STBY_EXIT - 1);

    rps_stby_t     st;
    logic [EW-1:0] ecnt;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            st   <= '0;
            ecnt <= '0;
        end else if (wr && wdata && ready) begin
            st.active  <= 1'b1;
            st.exiting <= 1'b0;
            ecnt       <= '0;
        end else if (wr && !wdata && st.active && !st.exiting) begin
            st.exiting <= 1'b1;
            ecnt       <= '0;
        end else if (st.exiting) begin
            if (ecnt == EXIT_LAST) begin
                st   <= '0;
                ecnt <= '0;
            end else begin
                ecnt <= ecnt + 1'b1;
            end
        end
    end

    assign active = st.active;

endmodule

// File: rtl/rps_rx_pwr.sv
module rps_rx_pwr (
    input  logic clk,
    input  logic rst,
    input  logic kill,
    input  logic ready,
    input  logic stby,
    input  logic apd_wr,
    input  logic apd_wdata,
    input  logic busy,
    output logic rx_pwr,
    output logic apd
);
    always_ff @(posedge clk) begin
        if (rst || kill) begin
            apd    <= 1'b0;
            rx_pwr <= 1'b0;
        end else begin
            if (apd_wr) apd <= apd_wdata;
            rx_pwr <= ready && !stby && (!apd || busy);
        end
    end
endmodule

// File: rtl/rdr_pwr_seq.sv
module rdr_pwr_seq
    import rps_pkg::*;
#(
    parameter int PULSE_MIN = 1356,
    parameter int RST_CYC   = 1356,
    parameter int INIT_CYC  = 2048,
    parameter int STBY_EXIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic por_i,
    input  logic pd_pin_i,
    input  logic stby_wr_i,
    input  logic stby_wdata_i,
    input  logic apd_wr_i,
    input  logic apd_wdata_i,
    input  logic rx_busy_i,
    output logic ph_hpd_o,
    output logic ph_rst_o,
    output logic ph_init_o,
    output logic ph_rdy_o,
    output logic clkbuf_en_o,
    output logic sink_en_o,
    output logic rx_pwr_o,
    output logic stby_bit_o,
    output logic apd_bit_o
);
    rps_phase_e phase;
    logic       kill;
    logic       armed;
    logic       stby;

    assign kill = por_i || pd_pin_i;

    rps_pulse_qual #(.PULSE_MIN(PULSE_MIN)) u_qual (
        .clk    (clk),
        .rst    (rst),
        .por    (por_i),
        .pin    (pd_pin_i),
        .in_hpd (phase == PH_HPD),
        .armed  (armed)
    );

    rps_phase_seq #(.RST_CYC(RST_CYC), .INIT_CYC(INIT_CYC)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .kill  (kill),
        .armed (armed),
        .phase (phase)
    );

    rps_standby #(.STBY_EXIT(STBY_EXIT)) u_stby (
        .clk    (clk),
        .rst    (rst),
        .kill   (kill),
        .ready  (phase == PH_RDY),
        .wr     (stby_wr_i),
        .wdata  (stby_wdata_i),
        .active (stby)
    );

    rps_rx_pwr u_rx (
        .clk       (clk),
        .rst       (rst),
        .kill      (kill),
        .ready     (phase == PH_RDY),
        .stby      (stby),
        .apd_wr    (apd_wr_i),
        .apd_wdata (apd_wdata_i),
        .busy      (rx_busy_i),
        .rx_pwr    (rx_pwr_o),
        .apd       (apd_bit_o)
    );

    assign ph_hpd_o    = (phase == PH_HPD);
    assign ph_rst_o    = (phase == PH_RST);
    assign ph_init_o   = (phase == PH_INIT);
    assign ph_rdy_o    = (phase == PH_RDY);
    assign clkbuf_en_o = !stby;
    assign sink_en_o   = !stby && (phase != PH_HPD);
    assign stby_bit_o  = stby;

endmodule

// File: rtl/rps_chk.sv
module rps_chk (
    input logic clk,
    input logic rst,
    input logic por_i,
    input logic pd_pin_i,
    input logic stby_wr_i,
    input logic stby_wdata_i,
    input logic rx_busy_i,
    input logic ph_hpd_o,
    input logic ph_rst_o,
    input logic ph_init_o,
    input logic ph_rdy_o,
    input logic clkbuf_en_o,
    input logic sink_en_o,
    input logic rx_pwr_o,
    input logic stby_bit_o,
    input logic apd_bit_o
);
    assert_sink_off_hpd_R1: assert property (@(posedge clk) disable iff (rst)
        ph_hpd_o |-> !sink_en_o);

    assert_kill_to_hpd_R2: assert property (@(posedge clk) disable iff (rst)
        (por_i || pd_pin_i) |=> (ph_hpd_o && !stby_bit_o && !apd_bit_o));

    assert_leave_hpd_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_rst_o) |-> ($past(ph_hpd_o) && !$past(por_i) && !$past(pd_pin_i)));

    assert_one_phase_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot({ph_hpd_o, ph_rst_o, ph_init_o, ph_rdy_o}));

    assert_init_after_rst_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_init_o) |-> $past(ph_rst_o));

    assert_rdy_after_init_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_rdy_o) |-> $past(ph_init_o));

    assert_stby_gates_R6: assert property (@(posedge clk) disable iff (rst)
        stby_bit_o |-> (!clkbuf_en_o && !sink_en_o));

    assert_stby_only_ready_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(stby_bit_o) |-> (ph_rdy_o && $past(stby_wr_i && stby_wdata_i)));

    assert_rx_needs_ready_R9: assert property (@(posedge clk) disable iff (rst)
        rx_pwr_o |-> $past(ph_rdy_o && !stby_bit_o));

    assert_rx_follows_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_pwr_o && $past(apd_bit_o)) |-> $past(rx_busy_i));

endmodule

bind rdr_pwr_seq rps_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .por_i        (por_i),
    .pd_pin_i     (pd_pin_i),
    .stby_wr_i    (stby_wr_i),
    .stby_wdata_i (stby_wdata_i),
    .rx_busy_i    (rx_busy_i),
    .ph_hpd_o     (ph_hpd_o),
    .ph_rst_o     (ph_rst_o),
    .ph_init_o    (ph_init_o),
    .ph_rdy_o     (ph_rdy_o),
    .clkbuf_en_o  (clkbuf_en_o),
    .sink_en_o    (sink_en_o),
    .rx_pwr_o     (rx_pwr_o),
    .stby_bit_o   (stby_bit_o),
    .apd_bit_o    (apd_bit_o)
);

// File: tb/tb_rdr_pwr_seq.sv
`timescale 1ns/1ps
module tb_rdr_pwr_seq;
    localparam int PM = 5;
    localparam int RC = 4;
    localparam int IC = 6;
    localparam int SX = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por = 1'b0, pin = 1'b0, swr = 1'b0, sdat = 1'b0;
    logic awr = 1'b0, adat = 1'b0, busy = 1'b0;
    logic hpd, phr, phi, rdy, cbe, ske, rxp, sbit, abit;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;
    bit cmp_on = 0;

    always #5 clk = ~clk;

    rdr_pwr_seq #(.PULSE_MIN(PM), .RST_CYC(RC), .INIT_CYC(IC), .STBY_EXIT(SX)) dut (
        .clk(clk), .rst(rst), .por_i(por), .pd_pin_i(pin),
        .stby_wr_i(swr), .stby_wdata_i(sdat), .apd_wr_i(awr), .apd_wdata_i(adat),
        .rx_busy_i(busy), .ph_hpd_o(hpd), .ph_rst_o(phr), .ph_init_o(phi),
        .ph_rdy_o(rdy), .clkbuf_en_o(cbe), .sink_en_o(ske), .rx_pwr_o(rxp),
        .stby_bit_o(sbit), .apd_bit_o(abit)
    );

    // ---- cycle model (phase: 0 off, 1 reset, 2 init, 3 ready) ----
    int m_ph = 0, m_pc = 0, m_hc = 0, m_ec = 0;
    bit m_arm = 1, m_act = 0, m_exi = 0, m_apd = 0, m_rx = 0;

    task automatic model_step();
        int nph = m_ph, npc = m_pc, nhc = m_hc, nec = m_ec;
        bit narm = m_arm, nact = m_act, nexi = m_exi, napd = m_apd, nrx = m_rx;
        bit kill = por || pin;
        if (rst) begin
            nph = 0; npc = 0; nhc = 0; nec = 0;
            narm = 1; nact = 0; nexi = 0; napd = 0; nrx = 0;
        end else begin
            if (por) begin narm = 1; nhc = 0; end
            else if (pin) begin
                if (m_hc >= PM - 1) narm = 1; else nhc = m_hc + 1;
            end else begin
                nhc = 0;
                if (m_ph == 0 && m_arm) narm = 0;
            end
            if (kill) begin nph = 0; npc = 0; end
            else case (m_ph)
                0: begin npc = 0; if (m_arm) nph = 1; end
                1: if (m_pc == RC - 1) begin nph = 2; npc = 0; end else npc = m_pc + 1;
                2: if (m_pc == IC - 1) begin nph = 3; npc = 0; end else npc = m_pc + 1;
                default: npc = 0;
            endcase
            if (kill) begin nact = 0; nexi = 0; nec = 0; end
            else if (swr && sdat && m_ph == 3) begin nact = 1; nexi = 0; nec = 0; end
            else if (swr && !sdat && m_act && !m_exi) begin nexi = 1; nec = 0; end
            else if (m_exi) begin
                if (m_ec == SX - 1) begin nact = 0; nexi = 0; nec = 0; end
                else nec = m_ec + 1;
            end
            if (kill) begin napd = 0; nrx = 0; end
            else begin
                if (awr) napd = adat;
                nrx = (m_ph == 3) && !m_act && (!m_apd || busy);
            end
        end
        m_ph = nph; m_pc = npc; m_hc = nhc; m_ec = nec;
        m_arm = narm; m_act = nact; m_exi = nexi; m_apd = napd; m_rx = nrx;
    endtask

    function automatic logic [8:0] exp_vec();
        return {m_ph == 0, m_ph == 1, m_ph == 2, m_ph == 3,
                !m_act, !m_act && m_ph != 0, m_rx, m_act, m_apd};
    endfunction

    always @(posedge clk) begin
        model_step();
        cmp_on <= 1'b1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison of all outputs against the model (R1, R2, R5, R6, R8, R9, R10)
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            logic [8:0] a;
            a = {hpd, phr, phi, rdy, cbe, ske, rxp, sbit, abit};
            chk(a == exp_vec(), "R5 model {hpd,rst,init,rdy,clkbuf,sink,rx,stby,apd}",
                32'(a), 32'(exp_vec()));
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        tick(3);
        chk({hpd, phr, phi, rdy, cbe, ske, rxp, sbit, abit} == 9'b1_0001_0000 && !ske,
            "R1 reset state", 32'({hpd, phr, phi, rdy, cbe, ske, rxp, sbit, abit}), 32'h110);
        rst = 1'b0;
        tick(1); chk(phr, "R4 reset phase after release", 32'(phr), 1);
        tick(RC); chk(phi, "R5 init after RST_CYC", 32'(phi), 1);
        tick(IC); chk(rdy, "R5 ready after INIT_CYC", 32'(rdy), 1);
        tick(1); chk(rxp, "R9 receiver on when auto-pd off", 32'(rxp), 1);
        awr = 1; adat = 1; tick(1); awr = 0;
        chk(abit, "R10 auto-pd bit written", 32'(abit), 1);
        tick(1); chk(!rxp, "R10 receiver off while idle", 32'(rxp), 0);
        busy = 1; tick(1); busy = 0;
        chk(rxp, "R10 receiver follows busy", 32'(rxp), 1);
        tick(1); chk(!rxp, "R10 receiver drops with busy", 32'(rxp), 0);
        swr = 1; sdat = 1; tick(1);
        chk(sbit && !cbe && !ske, "R6 standby entry", 32'({sbit, cbe, ske}), 32'b100);
        sdat = 0; tick(1); swr = 0;
        chk(sbit, "R8 bit held after clear", 32'(sbit), 1);
        tick(SX - 1); chk(sbit && !cbe, "R8 still in standby before exit", 32'({sbit, cbe}), 32'b10);
        tick(1); chk(!sbit && cbe, "R8 exit after STBY_EXIT", 32'({sbit, cbe}), 32'b01);
        swr = 1; sdat = 1; tick(1);
        sdat = 0; tick(1);
        sdat = 1; tick(1); swr = 0;
        tick(6); chk(sbit, "R8 write of 1 cancels exit", 32'(sbit), 1);
        swr = 1; sdat = 0; tick(1); swr = 0;
        tick(SX + 1); chk(!sbit, "R8 exit after cancel", 32'(sbit), 0);
        swr = 1; sdat = 1; tick(1); swr = 0;
        por = 1; tick(1); por = 0;
        chk(hpd && !sbit && !abit, "R2 por clears to hard power-down",
            32'({hpd, sbit, abit}), 32'b100);
        tick(1); chk(phr, "R3 por arms startup", 32'(phr), 1);
        swr = 1; sdat = 1; tick(1); swr = 0;
        chk(!sbit, "R7 standby ignored outside ready", 32'(sbit), 0);
        tick(RC + IC + 2); chk(rdy, "R5 ready again", 32'(rdy), 1);
        pin = 1; tick(PM - 1);
        chk(hpd, "R2 pin forces hard power-down", 32'(hpd), 1);
        pin = 0; tick(8);
        chk(hpd && !phr, "R3 short pulse does not start", 32'({hpd, phr}), 32'b10);
        pin = 1; tick(PM); pin = 0;
        tick(1); chk(phr, "R3 full-width pulse starts sequence", 32'(phr), 1);

        // constrained random phase
        begin
            int pin_left = 0;
            for (int c = 0; c < 6000; c++) begin
                por = ($urandom_range(0, 399) == 0);
                if (pin_left > 0) begin pin = 1; pin_left--; end
                else if ($urandom_range(0, 149) == 0) begin
                    pin = 1; pin_left = $urandom_range(0, 7);
                end else pin = 0;
                swr  = ($urandom_range(0, 19) == 0);
                sdat = $urandom_range(0, 1);
                awr  = ($urandom_range(0, 49) == 0);
                adat = $urandom_range(0, 1);
                busy = ($urandom_range(0, 2) == 0);
                tick(1);
            end
        end
        por = 0; pin = 0; swr = 0; awr = 0; busy = 0;
        tick(2);
        finish_run();
    end
endmodule